// File: doc/BRIEF.md
# Oversampled Serial Receiver with Four-Entry Character Queue

This block turns an asynchronous serial line into a stream of received characters for a processor. It runs on the system clock. A clock-enable tick at sixteen times the bit rate (the oversampling factor is a parameter) paces every line decision. The idle line is high (mark) and low is space. A character is a start bit, five to eight data bits sent least significant bit first, an optional parity or address bit, and a stop bit.

Every finished character goes into a four-entry queue together with its own flags: parity error, framing error, break, address and overrun. The processor sees the oldest entry on the output pins and removes it with a one-cycle pop strobe. A ready flag shows that the queue holds something, and a full flag shows that all four entries are taken. A start bit that does not last is dropped. A line held low for a whole character time is reported as a break, even when it starts partway through a character, and one-cycle pulses mark the start and the end of the break. In multidrop mode the extra bit tells address characters from data characters, and the receiver discards data characters until an address character wakes it.

Top module: `sio_rx_core`

## Requirements
- R1: `cfg_len_i` sets the number of data bits to 5 + `cfg_len_i` (0..3). The first data bit on the line lands in `rx_data_o[0]`, and data bits above the programmed length read as zero.
- R2: `cfg_par_i` selects the parity check: 0 none, 1 even (data plus parity bit carry an even number of ones), 2 odd, 3 fixed (the parity bit must equal `cfg_par_lvl_i`). When the check fails, `rx_perr_o` is set for that entry. Mode 0 adds no bit to the frame.
- R3: A falling edge is confirmed as a start bit only if the line is still low on the eighth tick after the tick that saw it low. Otherwise nothing is stored and the receiver goes back to looking for a start bit.
- R4: Data, parity and stop bits are sampled every 16 ticks after the start confirmation. A low stop bit followed by a return high before the break threshold stores the character with `rx_ferr_o` set.
- R5: Let FT = 16 x (total frame bits). A break is declared on the tick at which the line has been low for FT consecutive ticks, after a low stop bit. The break may begin inside a character. It stores one entry with data 0, `rx_brk_o` = 1 and `rx_ferr_o` = 1, and it pulses `brk_begin_o` for one cycle. `brk_end_o` pulses once on the first tick that sees the line high again. A low run of FT-1 ticks gives only a framing error.
- R6: The queue holds four entries in arrival order. `rdy_o` is high when at least one entry is held, and `full_o` when four are held. `pop_i` removes the oldest entry. A pop on an empty queue has no effect.
- R7: If a character completes while four entries are held and no pop occurs in that cycle, it overwrites the newest entry and sets that entry's `rx_ovr_o`. The three older entries stay unchanged.
- R8: With `cfg_mdrop_i` = 1, the bit after the data is an address flag shown on `rx_addr_o`, and no parity error is ever flagged. Raising `cfg_mdrop_i` puts the receiver to sleep. While asleep, entries with the address flag at 0 are discarded. An address character is stored and wakes the receiver.
- R9: After reset the queue is empty, `rdy_o` and `full_o` are low, the entry outputs read zero, and no break pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x_i | input | 1 | Oversampling clock enable, 16 per bit time |
| rxd_i | input | 1 | Serial line, high = mark |
| cfg_len_i | input | 2 | Data length code, bits = 5 + code |
| cfg_par_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 fixed |
| cfg_par_lvl_i | input | 1 | Expected parity bit level in fixed mode |
| cfg_mdrop_i | input | 1 | Multidrop address/data mode enable |
| pop_i | input | 1 | Remove oldest entry |
| rdy_o | output | 1 | Queue holds at least one entry |
| full_o | output | 1 | Queue holds four entries |
| rx_data_o | output | 8 | Oldest entry: data |
| rx_perr_o | output | 1 | Oldest entry: parity error |
| rx_ferr_o | output | 1 | Oldest entry: framing error |
| rx_brk_o | output | 1 | Oldest entry: break |
| rx_addr_o | output | 1 | Oldest entry: multidrop address flag |
| rx_ovr_o | output | 1 | Oldest entry: overwritten by overrun |
| brk_begin_o | output | 1 | One-cycle pulse at break detection |
| brk_end_o | output | 1 | One-cycle pulse when the line leaves break |

## Verification
A normal character reaches the queue outputs two clock cycles after the tick that samples its stop bit: one register in the framer and one in the queue. A framing-error or break entry instead follows the tick that first sees the line high, or the tick at which the low run reaches FT. The bench changes the line only just after a tick edge and holds every bit for 16 ticks, so each sample lands mid-bit. It reads entries at a falling clock edge only after the whole frame plus idle ticks have passed, which is well beyond the two-cycle latency. The break pulses are one cycle wide, so they are counted by a monitor and compared once the line has gone idle. The break threshold is tested at exactly FT-1 and FT low ticks.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_FIXED = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK_WAIT,
        ST_BRK_HOLD
    } rx_state_e;

    typedef struct packed {
        logic       ovr;
        logic       addr;
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_ent_t;

    // Parity check result: 1 means the received parity bit is wrong
    function automatic logic par_bad(par_mode_e mode, logic [7:0] d, logic p, logic lvl);
        logic ones_odd;
        ones_odd = ^{d, p};
        case (mode)
            PAR_EVEN:  par_bad = ones_odd;
            PAR_ODD:   par_bad = ~ones_odd;
            PAR_FIXED: par_bad = (p != lvl);
            default:   par_bad = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sio_rx_lowrun.sv
module sio_rx_lowrun #(
    parameter int RUN_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             rxd_i,
    output logic [RUN_W-1:0] run_o,
    output logic [RUN_W-1:0] run_nxt_o
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    // Saturating count of consecutive low ticks
    always_comb begin
        run_nxt_o = run_o;
        if (tick_i) begin
            if (rxd_i)
                run_nxt_o = '0;
            else if (run_o != RUN_MAX)
                run_nxt_o = run_o + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) run_o <= '0;
        else     run_o <= run_nxt_o;
    end

endmodule

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
    import sio_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int RUN_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             rxd_i,
    input  logic [1:0]       cfg_len_i,
    input  logic [1:0]       cfg_par_i,
    input  logic             cfg_par_lvl_i,
    input  logic             cfg_mdrop_i,
    input  logic [RUN_W-1:0] run_i,
    input  logic [RUN_W-1:0] run_nxt_i,
    output logic             push_o,
    output rx_ent_t          ent_o,
    output logic             brk_begin_o,
    output logic             brk_end_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

    rx_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       shreg;
    logic             pbit;
    logic             awake;

    logic             par_on;
    logic [2:0]       last_idx;
    logic [RUN_W-1:0] ft;
    rx_ent_t          cand;
    logic             keep_cand;
    logic             keep_brk;

    always_comb begin
        par_on    = cfg_mdrop_i || (par_mode_e'(cfg_par_i) != PAR_NONE);
        last_idx  = 3'(3'd4 + {1'b0, cfg_len_i});
        ft        = RUN_W'(OVS * (7 + int'(cfg_len_i) + (par_on ? 1 : 0)));
        cand      = '0;
        cand.data = shreg;
        cand.perr = cfg_mdrop_i ? 1'b0
                                : par_bad(par_mode_e'(cfg_par_i), shreg, pbit, cfg_par_lvl_i);
        cand.addr = cfg_mdrop_i & pbit;
        keep_cand = !cfg_mdrop_i || awake || cand.addr;
        keep_brk  = !cfg_mdrop_i || awake;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
            pbit        <= 1'b0;
            awake       <= 1'b0;
            push_o      <= 1'b0;
            ent_o       <= '0;
            brk_begin_o <= 1'b0;
            brk_end_o   <= 1'b0;
        end else begin
            push_o      <= 1'b0;
            brk_begin_o <= 1'b0;
            brk_end_o   <= 1'b0;
            if (!cfg_mdrop_i) awake <= 1'b0;
            if (tick_i) begin
                case (st)
                    ST_IDLE: begin
                        if (!rxd_i) begin
                            st      <= ST_START;
                            cnt     <= '0;
                            bit_idx <= '0;
                            shreg   <= '0;
                            pbit    <= 1'b0;
                        end
                    end
                    ST_START: begin
                        if (cnt == CNT_MID) begin
                            cnt <= '0;
                            st  <= rxd_i ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == CNT_LAST) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= rxd_i;
                            if (bit_idx == last_idx) st <= par_on ? ST_PAR : ST_STOP;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == CNT_LAST) begin
                            cnt  <= '0;
                            pbit <= rxd_i;
                            st   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == CNT_LAST) begin
                            cnt <= '0;
                            if (rxd_i) begin
                                ent_o  <= cand;
                                push_o <= keep_cand;
                                if (cfg_mdrop_i && cand.addr) awake <= 1'b1;
                                st     <= ST_IDLE;
                            end else begin
                                st <= ST_BRK_WAIT;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BRK_WAIT: begin
                        if (rxd_i) begin
                            ent_o      <= cand;
                            ent_o.ferr <= 1'b1;
                            push_o     <= keep_cand;
                            if (cfg_mdrop_i && cand.addr) awake <= 1'b1;
                            st         <= ST_IDLE;
                        end else if (run_nxt_i >= ft) begin
                            ent_o       <= '0;
                            ent_o.brk   <= 1'b1;
                            ent_o.ferr  <= 1'b1;
                            push_o      <= keep_brk;
                            brk_begin_o <= 1'b1;
                            st          <= ST_BRK_HOLD;
                        end
                    end
                    ST_BRK_HOLD: begin
                        if (rxd_i) begin
                            brk_end_o <= 1'b1;
                            st        <= ST_IDLE;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R5: a break is only announced once the low run counter has reached the threshold
    p_break_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
        brk_begin_o |-> (run_i >= ft));

    // R5: a break entry carries zero data with the framing flag
    p_break_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (push_o && ent_o.brk) |-> (ent_o.data == 8'h00 && ent_o.ferr));

    // R8: multidrop entries never report a parity error
    p_mdrop_no_perr_r8: assert property (@(posedge clk) disable iff (rst)
        (push_o && cfg_mdrop_i) |-> !ent_o.perr);

    // R3: a start bit that is high again at the confirm tick stores nothing next cycle
    p_false_start_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_START && tick_i && cnt == CNT_MID && rxd_i) |=> !push_o);

endmodule

// File: rtl/sio_rx_queue.sv
module sio_rx_queue
    import sio_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push_i,
    input  rx_ent_t ent_i,
    input  logic    pop_i,
    output rx_ent_t head_o,
    output logic    rdy_o,
    output logic    full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    rx_ent_t          mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] newest;
    logic [CNT_W-1:0] count;
    logic             do_pop;
    logic             do_wr;
    logic             do_ovr;
    rx_ent_t          ovr_ent;

    always_comb begin
        rdy_o       = (count != '0);
        full_o      = (count == CNT_W'(DEPTH));
        do_pop      = pop_i && rdy_o;
        do_wr       = push_i && (!full_o || do_pop);
        do_ovr      = push_i && full_o && !do_pop;
        newest      = (wr_ptr == '0) ? PTR_LAST : wr_ptr - 1'b1;
        ovr_ent     = ent_i;
        ovr_ent.ovr = 1'b1;
        head_o      = rdy_o ? mem[rd_ptr] : '0;
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[gi] <= '0;
            else if (do_wr && wr_ptr == PTR_W'(gi))
                mem[gi] <= ent_i;
            else if (do_ovr && newest == PTR_W'(gi))
                mem[gi] <= ovr_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr)  wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (do_wr && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_wr) count <= count - 1'b1;
        end
    end

    // R6: a stored character makes the queue ready in the next cycle
    p_push_sets_rdy_r6: assert property (@(posedge clk) disable iff (rst)
        push_i |=> rdy_o);

    // R6: popping a full queue without a push frees an entry
    p_pop_frees_r6: assert property (@(posedge clk) disable iff (rst)
        (pop_i && full_o && !push_i) |=> !full_o);

    // R7: an overrun keeps the queue full and marks the newest entry
    p_ovr_stays_full_r7: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o && !pop_i) |=> (full_o && mem[$past(newest)].ovr));

    // R9: reset leaves the queue empty
    p_reset_empty_r9: assert property (@(posedge clk)
        rst |=> (!rdy_o && !full_o));

endmodule

// File: rtl/sio_rx_core.sv
module sio_rx_core
    import sio_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_16x_i,
    input  logic       rxd_i,
    input  logic [1:0] cfg_len_i,
    input  logic [1:0] cfg_par_i,
    input  logic       cfg_par_lvl_i,
    input  logic       cfg_mdrop_i,
    input  logic       pop_i,
    output logic       rdy_o,
    output logic       full_o,
    output logic [7:0] rx_data_o,
    output logic       rx_perr_o,
    output logic       rx_ferr_o,
    output logic       rx_brk_o,
    output logic       rx_addr_o,
    output logic       rx_ovr_o,
    output logic       brk_begin_o,
    output logic       brk_end_o
);
    localparam int RUN_W = $clog2(OVS * 12) + 1;

    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] run_nxt;
    logic             push;
    rx_ent_t          ent;
    rx_ent_t          head;

    sio_rx_lowrun #(.RUN_W(RUN_W)) i_lowrun (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_16x_i),
        .rxd_i     (rxd_i),
        .run_o     (run),
        .run_nxt_o (run_nxt)
    );

    sio_rx_frame #(.OVS(OVS), .RUN_W(RUN_W)) i_frame (
        .clk           (clk),
        .rst           (rst),
        .tick_i        (tick_16x_i),
        .rxd_i         (rxd_i),
        .cfg_len_i     (cfg_len_i),
        .cfg_par_i     (cfg_par_i),
        .cfg_par_lvl_i (cfg_par_lvl_i),
        .cfg_mdrop_i   (cfg_mdrop_i),
        .run_i         (run),
        .run_nxt_i     (run_nxt),
        .push_o        (push),
        .ent_o         (ent),
        .brk_begin_o   (brk_begin_o),
        .brk_end_o     (brk_end_o)
    );

    sio_rx_queue #(.DEPTH(DEPTH)) i_queue (
        .clk    (clk),
        .rst    (rst),
        .push_i (push),
        .ent_i  (ent),
        .pop_i  (pop_i),
        .head_o (head),
        .rdy_o  (rdy_o),
        .full_o (full_o)
    );

    assign rx_data_o = head.data;
    assign rx_perr_o = head.perr;
    assign rx_ferr_o = head.ferr;
    assign rx_brk_o  = head.brk;
    assign rx_addr_o = head.addr;
    assign rx_ovr_o  = head.ovr;

    // R5: a break start and a break end never coincide
    p_brk_pulses_apart_r5: assert property (@(posedge clk) disable iff (rst)
        brk_begin_o |=> !brk_end_o);

endmodule

// File: tb/test_sio_rx_core.sv
module test_sio_rx_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_lvl = 1'b0;
    logic       cfg_mdrop = 1'b0;
    logic       pop = 1'b0;
    logic       rdy, full, perr, ferr, brk, addr, ovr, bbeg, bend;
    logic [7:0] data;

    int total = 0;
    int bad = 0;
    int n_beg = 0;
    int n_end = 0;

    always #2.5 clk = ~clk;
    always @(negedge clk) tick <= ~tick;
    always @(posedge clk) begin
        if (bbeg) n_beg <= n_beg + 1;
        if (bend) n_end <= n_end + 1;
    end

    sio_rx_core i_sio_rx_core (
        .clk(clk), .rst(rst), .tick_16x_i(tick), .rxd_i(rxd),
        .cfg_len_i(cfg_len), .cfg_par_i(cfg_par), .cfg_par_lvl_i(cfg_lvl),
        .cfg_mdrop_i(cfg_mdrop), .pop_i(pop), .rdy_o(rdy), .full_o(full),
        .rx_data_o(data), .rx_perr_o(perr), .rx_ferr_o(ferr), .rx_brk_o(brk),
        .rx_addr_o(addr), .rx_ovr_o(ovr), .brk_begin_o(bbeg), .brk_end_o(bend)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wait_tick();
        @(posedge clk);
        while (!tick) @(posedge clk);
        #1;
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit x_en,
                        input bit x_bit, input bit stopv);
        hold(1'b0, 16);
        for (int i = 0; i < nb; i++) hold(d[i], 16);
        if (x_en) hold(x_bit, 16);
        hold(stopv, 16);
        hold(1'b1, 6);
    endtask

    // Compare the oldest entry against expectations, then remove it
    task automatic expect_pop(input string req, input logic [7:0] d, input bit pe,
                              input bit fe, input bit bk, input bit ad, input bit ov);
        @(negedge clk);
        chk({req, " rdy"}, rdy, 1);
        chk({req, " data"}, data, d);
        chk({req, " perr"}, perr, pe);
        chk({req, " ferr"}, ferr, fe);
        chk({req, " brk"}, brk, bk);
        chk({req, " addr"}, addr, ad);
        chk({req, " ovr"}, ovr, ov);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    function automatic bit par_bit(input int pm, input logic [7:0] d, input bit lvl);
        case (pm)
            1: return ^d;
            2: return ~^d;
            default: return lvl;
        endcase
    endfunction

    initial begin
        #(150000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R9 rdy after reset", rdy, 0);
        chk("R9 full after reset", full, 0);
        chk("R9 data after reset", data, 0);
        rst = 1'b0;
        hold(1'b1, 20);
        chk("R9 no break pulse", n_beg + n_end, 0);

        // R3: a short low glitch is ignored, then a real character follows
        hold(1'b0, 4);
        hold(1'b1, 60);
        @(negedge clk);
        chk("R3 false start stores nothing", rdy, 0);
        send(8'hA5, 8, 0, 0, 1);
        expect_pop("R3 after glitch", 8'hA5, 0, 0, 0, 0, 0);

        // R1: five-bit length keeps only the low bits
        cfg_len = 2'd0;
        send(8'hFF, 5, 0, 0, 1);
        expect_pop("R1 len5", 8'h1F, 0, 0, 0, 0, 0);
        cfg_len = 2'd2;
        send(8'h55, 7, 0, 0, 1);
        expect_pop("R1 len7", 8'h55, 0, 0, 0, 0, 0);

        // R2: fixed parity, wrong and right level
        cfg_len = 2'd3; cfg_par = 2'd3; cfg_lvl = 1'b1;
        send(8'h3C, 8, 1, 0, 1);
        expect_pop("R2 fixed wrong", 8'h3C, 1, 0, 0, 0, 0);
        send(8'h3C, 8, 1, 1, 1);
        expect_pop("R2 fixed right", 8'h3C, 0, 0, 0, 0, 0);

        // R5/R4 threshold: len5, no parity, FT = 112 low ticks
        cfg_len = 2'd0; cfg_par = 2'd0;
        hold(1'b0, 111);
        hold(1'b1, 20);
        expect_pop("R4 FT-1 low is framing", 8'h00, 0, 1, 0, 0, 0);
        chk("R4 no break at FT-1", n_beg, 0);
        hold(1'b0, 112);
        hold(1'b1, 20);
        expect_pop("R5 FT low is break", 8'h00, 0, 1, 1, 0, 0);
        chk("R5 begin pulse", n_beg, 1);
        chk("R5 end pulse", n_end, 1);
        @(negedge clk);
        chk("R5 single break entry", rdy, 0);

        // R5: break starting in the middle of a character
        cfg_len = 2'd3;
        hold(1'b0, 16);
        hold(1'b1, 48);
        hold(1'b0, 200);
        hold(1'b1, 20);
        expect_pop("R5 mid-character break", 8'h00, 0, 1, 1, 0, 0);
        chk("R5 mid begin pulse", n_beg, 2);
        chk("R5 mid end pulse", n_end, 2);
        @(negedge clk);
        chk("R5 mid no extra entry", rdy, 0);

        // R6/R7: fill, then overrun
        send(8'h11, 8, 0, 0, 1);
        send(8'h22, 8, 0, 0, 1);
        send(8'h33, 8, 0, 0, 1);
        @(negedge clk);
        chk("R6 three not full", full, 0);
        send(8'h44, 8, 0, 0, 1);
        @(negedge clk);
        chk("R6 four full", full, 1);
        send(8'h55, 8, 0, 0, 1);
        @(negedge clk);
        chk("R7 still full", full, 1);
        expect_pop("R7 oldest kept", 8'h11, 0, 0, 0, 0, 0);
        chk("R6 full cleared by pop", full, 0);
        expect_pop("R7 second kept", 8'h22, 0, 0, 0, 0, 0);
        expect_pop("R7 third kept", 8'h33, 0, 0, 0, 0, 0);
        expect_pop("R7 newest overwritten", 8'h55, 0, 0, 0, 0, 1);
        chk("R6 empty after pops", rdy, 0);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        send(8'h66, 8, 0, 0, 1);
        expect_pop("R6 pop on empty ignored", 8'h66, 0, 0, 0, 0, 0);

        // R8: multidrop sleep and wake
        cfg_par = 2'd1; cfg_mdrop = 1'b1;
        send(8'h12, 8, 1, 0, 1);
        @(negedge clk);
        chk("R8 data discarded asleep", rdy, 0);
        send(8'h7E, 8, 1, 1, 1);
        expect_pop("R8 address wakes", 8'h7E, 0, 0, 0, 1, 0);
        send(8'h05, 8, 1, 0, 1);
        expect_pop("R8 data after wake", 8'h05, 0, 0, 0, 0, 0);
        cfg_mdrop = 1'b0; cfg_par = 2'd0;
        hold(1'b1, 4);

        // Random characters: R1 R2 R4
        for (int k = 0; k < 40; k++) begin
            int         lc;
            int         pm;
            int         nb;
            bit         lvl;
            bit         corrupt;
            bit         fe;
            bit         pb;
            logic [7:0] d;
            logic [7:0] msk;
            lc      = $urandom % 4;
            pm      = $urandom % 4;
            lvl     = 1'($urandom % 2);
            corrupt = ($urandom % 4) == 0;
            fe      = ($urandom % 8) == 0;
            nb      = 5 + lc;
            msk     = 8'((1 << nb) - 1);
            d       = 8'($urandom) & msk;
            if (fe) d = d | 8'h01;
            cfg_len = 2'(lc); cfg_par = 2'(pm); cfg_lvl = lvl;
            pb = par_bit(pm, d, lvl) ^ corrupt;
            send(d, nb, pm != 0, pb, !fe);
            expect_pop("R2 R4 random", d, corrupt && pm != 0, fe, 0, 0, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule